// File: doc/BRIEF.md
# Secondary Interrupt Controller with Direct Routing

This block gathers up to 32 level-sensitive interrupt requests and presents them to a primary interrupt controller. Each request is copied into a raw-level register on every clock. A software-controlled enable mask selects which requests count toward a single summary request, which is driven on the top output line. A parameterised band of lines (21 to 30 by default) can also bypass the summary. When its routing bit is set, such a line drives the primary-controller output with the same index.

Software reaches the block through a simple 32-bit register port. An access uses valid, write, byte address and write data, and completes in the cycle it is presented. The register is chosen by the word index, which is the byte address shifted right by two, within a 4 KB window. The enable mask and the routing register are changed only through separate set and clear registers, so a driver never needs a read-modify-write. Two soft-request registers give a shortcut to enable bit 0.

Top module: `sic_top`

## Requirements
- R1: The raw-level register copies `irq_in` on every clock edge. Reading word index 1 returns it.
- R2: Reading word index 0 returns the raw level ANDed with the enable mask. Reading word index 2 returns the enable mask.
- R3: Writing word index 2 ORs the write data into the enable mask. Writing word index 3 clears every mask bit that is 1 in the write data.
- R4: Reading word index 4 returns raw-level bit 0 in bit 0, with all other bits zero. A write of any nonzero value to index 4 sets mask bit 0, and a nonzero write to index 5 clears it, whichever data bits are 1. A zero write to either index changes nothing.
- R5: Writing word index 8 ORs the write data ANDed with 0x7FE00000 into the routing register, so only bits 21 to 30 can ever be 1. Reading index 8 returns the routing register.
- R6: Writing word index 9 clears every routing bit that is 1 in the write data.
- R7: Output line 31 is high exactly when the raw level ANDed with the enable mask is nonzero.
- R8: For each line i from 21 to 30 whose routing bit is set, `irq_out[i]` follows raw-level bit i.
- R9: Output lines 0 to 20 are always low. Lines 21 to 30 are low while their routing bit is clear.
- R10: Every output is registered. An input presented before clock edge E reaches `irq_out` after edge E+1. A register write accepted at edge E changes `irq_out` after edge E+1.
- R11: Reads of word indices 3, 5, 6, 7, 9 and 10 and above return zero. Writes to indices 0, 1, 6, 7 and 10 and above change no state and no output.
- R12: A synchronous active-high `rst` clears the raw level, the enable mask and the routing register, and drives every output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Level-sensitive interrupt requests |
| bus_valid | input | 1 | Register access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window; bits [11:2] are the word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access, zero otherwise |
| irq_out | output | 32 | Lines toward the primary controller; bit 31 is the summary |

## Verification
The soft-request clear register is tested with data whose bit 0 is zero. A design that tests bit 0 instead of the whole word would leave the enable bit set. The routing register is written with all ones. A design that drops the 0x7FE00000 filter would read back bits outside 21 to 30, and would drive low-numbered outputs. Exact-cycle checks after an input change and after a routing write catch an extra or a missing register stage. Writes of all ones to read-only and unmapped indices, followed by readback of the mask and routing registers, catch a decoder that aliases those indices onto real registers.

// File: rtl/sic_pkg.sv
package sic_pkg;

   // Word indices; software depends on these positions.
   localparam int unsigned IDX_STATUS   = 0;
   localparam int unsigned IDX_RAW      = 1;
   localparam int unsigned IDX_EN_SET   = 2;
   localparam int unsigned IDX_EN_CLR   = 3;
   localparam int unsigned IDX_SOFT_SET = 4;
   localparam int unsigned IDX_SOFT_CLR = 5;
   localparam int unsigned IDX_RT_SET   = 8;
   localparam int unsigned IDX_RT_CLR   = 9;

   localparam int unsigned MAX_LINES = 256;

   // Contiguous bit band [lo, hi] as a wide mask.
   function automatic logic [MAX_LINES-1:0] band_mask(int unsigned lo, int unsigned hi);
      logic [MAX_LINES-1:0] m;
      m = '0;
      for (int unsigned b = 0; b < MAX_LINES; b++) begin
         if (b >= lo && b <= hi) m[b] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/sic_level_latch.sv
module sic_level_latch #(
   parameter int unsigned N = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] irq_in,
   output logic [N-1:0] raw_q
);

   always_ff @(posedge clk) begin
      if (rst) raw_q <= '0;
      else     raw_q <= irq_in;
   end

endmodule

// File: rtl/sic_regs.sv
module sic_regs
   import sic_pkg::*;
#(
   parameter int unsigned N     = 32,
   parameter int unsigned DW    = 32,
   parameter int unsigned AW    = 12,
   parameter int unsigned RT_LO = 21,
   parameter int unsigned RT_HI = 30
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          bus_valid,
   input  logic          bus_write,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   input  logic [N-1:0]  raw_q,
   output logic [DW-1:0] bus_rdata,
   output logic [N-1:0]  en_q,
   output logic [N-1:0]  rt_q
);

   localparam int unsigned IW = AW - 2;
   localparam logic [N-1:0] RT_MASK = N'(band_mask(RT_LO, RT_HI));

   if (N > DW) begin : g_chk_width
      $error("sic_regs: line count exceeds data width");
   end
   if (IW < 4) begin : g_chk_addr
      $error("sic_regs: address window too small for register set");
   end

   logic [IW-1:0] idx;
   logic [N-1:0]  wbits;
   logic          wr_nonzero;
   logic          do_wr;
   logic          do_rd;
   logic          unused_lsb;

   assign idx        = bus_addr[AW-1:2];
   assign wbits      = bus_wdata[N-1:0];
   assign wr_nonzero = |bus_wdata;
   assign do_wr      = bus_valid & bus_write;
   assign do_rd      = bus_valid & ~bus_write;
   assign unused_lsb = ^bus_addr[1:0];

   logic [N-1:0] en_d;
   logic [N-1:0] rt_d;

   always_comb begin
      en_d = en_q;
      rt_d = rt_q;
      if (do_wr) begin
         case (idx)
            IW'(IDX_EN_SET):   en_d = en_q | wbits;
            IW'(IDX_EN_CLR):   en_d = en_q & ~wbits;
            IW'(IDX_SOFT_SET): if (wr_nonzero) en_d[0] = 1'b1;
            IW'(IDX_SOFT_CLR): if (wr_nonzero) en_d[0] = 1'b0;
            IW'(IDX_RT_SET):   rt_d = rt_q | (wbits & RT_MASK);
            IW'(IDX_RT_CLR):   rt_d = rt_q & ~wbits;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q <= '0;
         rt_q <= '0;
      end else begin
         en_q <= en_d;
         rt_q <= rt_d;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (do_rd) begin
         case (idx)
            IW'(IDX_STATUS):   bus_rdata = DW'(raw_q & en_q);
            IW'(IDX_RAW):      bus_rdata = DW'(raw_q);
            IW'(IDX_EN_SET):   bus_rdata = DW'(en_q);
            IW'(IDX_SOFT_SET): bus_rdata = DW'(raw_q[0]);
            IW'(IDX_RT_SET):   bus_rdata = DW'(rt_q);
            default:           bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/sic_out_stage.sv
module sic_out_stage #(
   parameter int unsigned N        = 32,
   parameter int unsigned RT_LO    = 21,
   parameter int unsigned RT_HI    = 30,
   parameter int unsigned SUM_LINE = 31
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] raw_q,
   input  logic [N-1:0] en_q,
   input  logic [N-1:0] rt_q,
   output logic [N-1:0] irq_out
);

   logic any_pending;
   logic unused_rt;

   assign any_pending = |(raw_q & en_q);
   assign unused_rt   = ^rt_q;

   for (genvar i = 0; i < int'(N); i++) begin : g_line
      if (i == int'(SUM_LINE)) begin : g_sum
         logic q;
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= any_pending;
         end
         assign irq_out[i] = q;
      end else if (i >= int'(RT_LO) && i <= int'(RT_HI)) begin : g_route
         logic q;
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= raw_q[i] & rt_q[i];
         end
         assign irq_out[i] = q;
      end else begin : g_tie
         assign irq_out[i] = 1'b0;
      end
   end

endmodule

// File: rtl/sic_top.sv
module sic_top #(
   parameter int unsigned N        = 32,
   parameter int unsigned DW       = 32,
   parameter int unsigned AW       = 12,
   parameter int unsigned RT_LO    = 21,
   parameter int unsigned RT_HI    = 30,
   parameter int unsigned SUM_LINE = N - 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [N-1:0]  irq_in,
   input  logic          bus_valid,
   input  logic          bus_write,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic [N-1:0]  irq_out
);

   if (N < 2 || N > sic_pkg::MAX_LINES) begin : g_chk_n
      $error("sic_top: line count out of range");
   end
   if (RT_LO > RT_HI || RT_HI >= N) begin : g_chk_band
      $error("sic_top: routing band outside line range");
   end
   if (SUM_LINE >= N || (SUM_LINE >= RT_LO && SUM_LINE <= RT_HI)) begin : g_chk_sum
      $error("sic_top: summary line misplaced");
   end

   logic [N-1:0] raw_q;
   logic [N-1:0] en_q;
   logic [N-1:0] rt_q;

   sic_level_latch #(.N(N)) u_latch (
      .clk    (clk),
      .rst    (rst),
      .irq_in (irq_in),
      .raw_q  (raw_q)
   );

   sic_regs #(
      .N(N), .DW(DW), .AW(AW), .RT_LO(RT_LO), .RT_HI(RT_HI)
   ) u_regs (
      .clk       (clk),
      .rst       (rst),
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .raw_q     (raw_q),
      .bus_rdata (bus_rdata),
      .en_q      (en_q),
      .rt_q      (rt_q)
   );

   sic_out_stage #(
      .N(N), .RT_LO(RT_LO), .RT_HI(RT_HI), .SUM_LINE(SUM_LINE)
   ) u_out (
      .clk     (clk),
      .rst     (rst),
      .raw_q   (raw_q),
      .en_q    (en_q),
      .rt_q    (rt_q),
      .irq_out (irq_out)
   );

endmodule

// File: rtl/sic_top_chk.sv
module sic_top_chk
   import sic_pkg::*;
#(
   parameter int unsigned N        = 32,
   parameter int unsigned DW       = 32,
   parameter int unsigned AW       = 12,
   parameter int unsigned RT_LO    = 21,
   parameter int unsigned RT_HI    = 30,
   parameter int unsigned SUM_LINE = 31
) (
   input logic          clk,
   input logic          rst,
   input logic [N-1:0]  irq_in,
   input logic          bus_valid,
   input logic          bus_write,
   input logic [AW-1:0] bus_addr,
   input logic [DW-1:0] bus_wdata,
   input logic [N-1:0]  raw_q,
   input logic [N-1:0]  en_q,
   input logic [N-1:0]  rt_q,
   input logic [N-1:0]  irq_out
);

   localparam int unsigned IW = AW - 2;
   localparam logic [N-1:0] RT_MASK  = N'(band_mask(RT_LO, RT_HI));
   localparam logic [N-1:0] SUM_MASK = N'(band_mask(SUM_LINE, SUM_LINE));

   logic [IW-1:0] idx;
   logic [N-1:0]  wv;
   logic          wr;
   logic          wr_undef;
   logic          unused_lsb;

   assign idx        = bus_addr[AW-1:2];
   assign wv         = bus_wdata[N-1:0];
   assign wr         = bus_valid & bus_write;
   assign unused_lsb = ^bus_addr[1:0];
   assign wr_undef   = wr && !(idx == IW'(IDX_EN_SET) || idx == IW'(IDX_EN_CLR) ||
                               idx == IW'(IDX_SOFT_SET) || idx == IW'(IDX_SOFT_CLR) ||
                               idx == IW'(IDX_RT_SET) || idx == IW'(IDX_RT_CLR));

   AST_RAW_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> raw_q == $past(irq_in)); // R1
   AST_EN_SET_ORS: assert property (@(posedge clk) disable iff (rst)
      (wr && idx == IW'(IDX_EN_SET)) |=> (en_q & $past(wv)) == $past(wv)); // R3
   AST_EN_CLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (wr && idx == IW'(IDX_EN_CLR)) |=> (en_q & $past(wv)) == '0); // R3
   AST_SOFT_SET_BIT0: assert property (@(posedge clk) disable iff (rst)
      (wr && idx == IW'(IDX_SOFT_SET) && (|bus_wdata)) |=> en_q[0]); // R4
   AST_SOFT_CLR_BIT0: assert property (@(posedge clk) disable iff (rst)
      (wr && idx == IW'(IDX_SOFT_CLR) && (|bus_wdata)) |=> !en_q[0]); // R4
   AST_ROUTE_IN_BAND: assert property (@(posedge clk) disable iff (rst)
      (rt_q & ~RT_MASK) == '0); // R5
   AST_ROUTE_CLR: assert property (@(posedge clk) disable iff (rst)
      (wr && idx == IW'(IDX_RT_CLR)) |=> (rt_q & $past(wv)) == '0); // R6
   AST_SUMMARY_LINE: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> irq_out[SUM_LINE] == (|($past(raw_q & en_q)))); // R7
   AST_ROUTED_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (irq_out & RT_MASK) == ($past(raw_q & rt_q) & RT_MASK)); // R8
   AST_OTHER_LINES_LOW: assert property (@(posedge clk) disable iff (rst)
      (irq_out & ~(RT_MASK | SUM_MASK)) == '0); // R9
   AST_UNDEF_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
      wr_undef |=> $stable(en_q) && $stable(rt_q)); // R11
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> en_q == '0 && rt_q == '0 && irq_out == '0); // R12

endmodule

bind sic_top sic_top_chk #(
   .N(N), .DW(DW), .AW(AW), .RT_LO(RT_LO), .RT_HI(RT_HI), .SUM_LINE(SUM_LINE)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .irq_in    (irq_in),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .raw_q     (raw_q),
   .en_q      (en_q),
   .rt_q      (rt_q),
   .irq_out   (irq_out)
);

// File: tb/tb_sic_top.sv
module tb_sic_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] BAND = 32'h7FE0_0000;

   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] irq_in;
   logic        bus_valid;
   logic        bus_write;
   logic [11:0] bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic [31:0] irq_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   logic [31:0] m_in, m_en, m_rt;

   always #(CLK_PERIOD/2) clk = ~clk;

   sic_top dut (
      .clk(clk), .rst(rst), .irq_in(irq_in), .bus_valid(bus_valid),
      .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   function automatic logic [31:0] exp_out();
      logic [31:0] e;
      e = m_in & m_rt & BAND;
      e[31] = |(m_in & m_en);
      return e;
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   task automatic drive_in(logic [31:0] v);
      @(negedge clk);
      irq_in = v;
      m_in   = v;
      settle();
   endtask

   task automatic wr(int idx, logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1;
      bus_addr  = 12'(idx << 2); bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      case (idx)
         2: m_en = m_en | d;
         3: m_en = m_en & ~d;
         4: if (d != 0) m_en[0] = 1'b1;
         5: if (d != 0) m_en[0] = 1'b0;
         8: m_rt = m_rt | (d & BAND);
         9: m_rt = m_rt & ~d;
         default: ;
      endcase
   endtask

   task automatic rd(int idx, output logic [31:0] v);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'(idx << 2);
      #1 v = bus_rdata;
      bus_valid = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R12", "outputs after reset", irq_out, 32'h0);
      rd(2, v); check("R12", "mask after reset", v, 32'h0);
      rd(8, v); check("R12", "routing after reset", v, 32'h0);
      rd(1, v); check("R12", "raw after reset", v, 32'h0);
   endtask

   task automatic t_raw();
      logic [31:0] v;
      drive_in(32'hA5A5_0F0F);
      rd(1, v); check("R1", "raw level", v, 32'hA5A5_0F0F);
      rd(0, v); check("R2", "status with empty mask", v, 32'h0);
      check("R9", "outputs with nothing enabled", irq_out, 32'h0);
      drive_in(32'h0000_F0F1);
      rd(1, v); check("R1", "raw level second pattern", v, 32'h0000_F0F1);
   endtask

   task automatic t_enable();
      logic [31:0] v;
      wr(2, 32'h0000_00FF);
      rd(2, v); check("R2", "mask read", v, m_en);
      wr(2, 32'h0F00_0000);
      rd(2, v); check("R3", "mask set ORs", v, 32'h0F00_00FF);
      rd(0, v); check("R2", "status", v, m_in & m_en);
      settle(); check("R7", "summary high", irq_out, exp_out());
      wr(3, 32'h0000_00F1);
      rd(2, v); check("R3", "mask clear", v, 32'h0F00_000E);
      settle(); check("R7", "summary after clear", irq_out, exp_out());
      wr(3, 32'hFFFF_FFFF);
      settle(); check("R7", "summary low", irq_out, 32'h0);
   endtask

   task automatic t_latency();
      drive_in(32'h0);
      wr(2, 32'h0000_0020);
      settle();
      @(negedge clk); irq_in = 32'h0000_0020; m_in = irq_in;
      @(posedge clk); #1;
      check("R10", "summary one edge after input", {31'h0, irq_out[31]}, 32'h0);
      @(posedge clk); #1;
      check("R10", "summary two edges after input", {31'h0, irq_out[31]}, 32'h1);
      drive_in(32'h0040_0000);
      wr(3, 32'hFFFF_FFFF);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'(8 << 2); bus_wdata = 32'h0040_0000;
      @(posedge clk); #1;
      bus_valid = 1'b0; bus_write = 1'b0;
      check("R10", "routed line at write edge", irq_out, 32'h0);
      m_rt = 32'h0040_0000;
      @(posedge clk); #1;
      check("R10", "routed line one edge later", irq_out, 32'h0040_0000);
      wr(9, 32'hFFFF_FFFF);
      settle();
   endtask

   task automatic t_soft();
      logic [31:0] v;
      wr(3, 32'hFFFF_FFFF);
      drive_in(32'h0000_0003);
      rd(4, v); check("R4", "soft read bit 0 only", v, 32'h1);
      wr(4, 32'h0);
      rd(2, v); check("R4", "zero soft set inert", v, 32'h0);
      wr(4, 32'h0000_0100);
      rd(2, v); check("R4", "nonzero soft set", v, 32'h1);
      settle(); check("R7", "summary from soft bit", irq_out, exp_out());
      wr(5, 32'h0);
      rd(2, v); check("R4", "zero soft clear inert", v, 32'h1);
      wr(5, 32'h8000_0000);
      rd(2, v); check("R4", "nonzero soft clear", v, 32'h0);
      drive_in(32'h0000_0002);
      rd(4, v); check("R4", "soft read with bit 0 low", v, 32'h0);
   endtask

   task automatic t_route();
      logic [31:0] v;
      wr(8, 32'hFFFF_FFFF);
      rd(8, v); check("R5", "routing filtered", v, 32'h7FE0_0000);
      drive_in(32'hFFFF_FFFF);
      check("R8", "all band lines routed", irq_out, exp_out());
      check("R9", "low lines stay low", irq_out & 32'h001F_FFFF, 32'h0);
      wr(9, 32'h0FE0_0000);
      rd(8, v); check("R6", "routing clear", v, 32'h7000_0000);
      settle(); check("R9", "unrouted band lines low", irq_out, exp_out());
      drive_in(32'h5000_0000);
      check("R8", "routed lines follow input", irq_out, 32'h5000_0000);
      wr(9, 32'hFFFF_FFFF);
   endtask

   task automatic t_undef();
      logic [31:0] v;
      wr(2, 32'h1234_5678);
      wr(8, 32'h0120_0000);
      drive_in(32'hFFFF_FFFF);
      foreach (v[k]) begin end
      rd(3, v); check("R11", "read idx 3", v, 32'h0);
      rd(5, v); check("R11", "read idx 5", v, 32'h0);
      rd(6, v); check("R11", "read idx 6", v, 32'h0);
      rd(9, v); check("R11", "read idx 9", v, 32'h0);
      rd(10, v); check("R11", "read idx 10", v, 32'h0);
      rd(1023, v); check("R11", "read top idx", v, 32'h0);
      wr(0, 32'hFFFF_FFFF);
      wr(1, 32'hFFFF_FFFF);
      wr(6, 32'hFFFF_FFFF);
      wr(7, 32'hFFFF_FFFF);
      wr(1023, 32'hFFFF_FFFF);
      rd(2, v); check("R11", "mask untouched", v, 32'h1234_5678);
      rd(8, v); check("R11", "routing untouched", v, 32'h0120_0000);
      settle(); check("R11", "outputs untouched", irq_out, exp_out());
   endtask

   task automatic t_mid_reset();
      logic [31:0] v;
      @(negedge clk); rst = 1'b1;
      irq_in = 32'h0; m_in = 32'h0; m_en = 32'h0; m_rt = 32'h0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check("R12", "outputs after mid reset", irq_out, 32'h0);
      rd(2, v); check("R12", "mask after mid reset", v, 32'h0);
      rd(8, v); check("R12", "routing after mid reset", v, 32'h0);
   endtask

   initial begin
      rst = 1'b1; irq_in = '0; bus_valid = 1'b0; bus_write = 1'b0;
      bus_addr = '0; bus_wdata = '0;
      m_in = '0; m_en = '0; m_rt = '0;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_raw();
      t_enable();
      t_latency();
      t_soft();
      t_route();
      t_undef();
      t_mid_reset();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule